// File: doc/BRIEF.md
# Unicast Station Address Filter

This block keeps a small table of unicast station addresses and tells the receive path whether the destination address of an incoming frame belongs to this station. Software loads each entry through a register-style write port. The write is split into two transactions: a low 32-bit word followed by a high 16-bit word. An entry takes part in matching only after its high word has arrived and only when the full 48-bit address is not all zeros.

The frame side presents a 48-bit destination address together with a strobe. One clock later the block returns a result strobe, a hit flag and the index of the matching entry. When several entries hold the same address, the lowest index is reported.

At boot, firmware can replace entry 0 with an alternate station address. The replacement is skipped when the alternate pointer says that no alternate exists. It is also skipped when the alternate address is a group address. In both cases entry 0 keeps whatever it held before.

Top module: `rx_station_filter`

## Requirements
- R1: After reset every entry is invalid, so no lookup hits, including a lookup of the all-zero address.
- R2: Address byte k sits in bits 8k+7:8k of every 48-bit bus (`lookup_da`, `alt_addr`). A low-word write carries bytes 0..3 in data bits 31:0, with byte 0 in bits 7:0. A high-word write carries byte 4 in data bits 7:0 and byte 5 in data bits 15:8.
- R3: A low-word write (`cfg_wr_hi`=0) invalidates its entry. The entry takes part in matching again only after a high-word write (`cfg_wr_hi`=1) to the same index.
- R4: A high-word write sets the entry valid only when the combined 48-bit address is nonzero. An all-zero entry never matches.
- R5: Bits 31:16 of a high-word write have no effect on the stored address or on matching.
- R6: Each `lookup_vld` cycle produces exactly one `hit_vld` pulse on the following clock. `hit` and `hit_idx` in that cycle reflect the table as it stood at the lookup edge. `hit_vld` stays low when no lookup is presented, and `hit_idx` is 0 whenever `hit` is low.
- R7: When several valid entries match, `hit_idx` reports the lowest index.
- R8: An `alt_req` pulse whose pointer is neither 16'h0000 nor 16'hFFFF, and whose address has bit 0 of byte 0 clear, loads `alt_addr` into entry 0. Entry 0 is valid afterwards if that address is nonzero.
- R9: An `alt_req` whose pointer is 16'h0000 or 16'hFFFF leaves entry 0 unchanged.
- R10: An `alt_req` whose address has bit 0 of byte 0 set (a group address) leaves entry 0 unchanged.
- R11: When an accepted alternate load and a configuration write to entry 0 fall in the same cycle, the alternate address wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_idx | input | IDXW | Entry index of the write |
| cfg_wr_hi | input | 1 | 0 selects the low word, 1 selects the high word |
| cfg_wr_data | input | 32 | Write data |
| alt_req | input | 1 | Alternate-address load pulse |
| alt_ptr | input | 16 | Alternate pointer; 16'h0000 and 16'hFFFF mean that no alternate exists |
| alt_addr | input | 48 | Alternate station address |
| lookup_vld | input | 1 | Destination-address strobe |
| lookup_da | input | 48 | Destination address to compare |
| hit_vld | output | 1 | Result strobe, one clock after `lookup_vld` |
| hit | output | 1 | A valid entry matched |
| hit_idx | output | IDXW | Lowest matching index, 0 on a miss |

## Verification
The properties assume that a configuration write to entry 0 and an alternate load do not both target entry 0 while the stability of entry 0 is being checked. For that reason the rejection properties exclude cycles with a concurrent write to entry 0. The stimulus keeps every strobe to a single cycle. The only overlap of an alternate load and a write to entry 0 is the deliberate one that tests alternate priority. Lookups are issued both in isolation and back to back, so that the one-cycle latency is exercised with no idle gap.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  localparam int unsigned MAC_W = 48;
  localparam int unsigned LO_W  = 32;
  localparam int unsigned HI_W  = MAC_W - LO_W;
  localparam logic [15:0] ALT_PTR_EMPTY = 16'h0000;
  localparam logic [15:0] ALT_PTR_BLANK = 16'hFFFF;

  typedef struct packed {
    logic [HI_W-1:0] hi;
    logic [LO_W-1:0] lo;
  } station_addr_t;

  // Bit 0 of byte 0 marks a group (multicast/broadcast) address.
  function automatic logic is_group(input logic [MAC_W-1:0] a);
    return a[0];
  endfunction
endpackage

// File: rtl/rsf_alt_gate.sv
module rsf_alt_gate
  import rsf_pkg::*;
(
  input  logic             alt_req,
  input  logic [15:0]      alt_ptr,
  input  logic [MAC_W-1:0] alt_addr,
  output logic             alt_take
);
  logic ptr_ok;

  always_comb begin
    ptr_ok   = (alt_ptr != ALT_PTR_EMPTY) && (alt_ptr != ALT_PTR_BLANK);
    alt_take = alt_req && ptr_ok && !is_group(alt_addr);
  end
endmodule

// File: rtl/rsf_entry_bank.sv
module rsf_entry_bank
  import rsf_pkg::*;
#(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned IDXW  = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDXW-1:0]             wr_idx,
  input  logic                        wr_hi,
  input  logic [LO_W-1:0]             wr_data,
  input  logic                        alt_take,
  input  logic [MAC_W-1:0]            alt_addr,
  output logic [DEPTH-1:0][MAC_W-1:0] ent_addr,
  output logic [DEPTH-1:0]            ent_valid
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    station_addr_t addr_q, addr_d;
    logic          vld_q, vld_d;
    logic          sel, en;

    always_comb begin
      sel    = wr_en && (wr_idx == IDXW'(g));
      addr_d = addr_q;
      vld_d  = vld_q;
      if (sel && !wr_hi) begin
        addr_d.lo = wr_data;
        vld_d     = 1'b0;
      end
      if (sel && wr_hi) begin
        addr_d.hi = wr_data[HI_W-1:0];
        vld_d     = ({wr_data[HI_W-1:0], addr_q.lo} != '0);
      end
      en = sel;
      if (g == 0) begin
        if (alt_take) begin
          addr_d = station_addr_t'(alt_addr);
          vld_d  = (alt_addr != '0);
          en     = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= '0;
        vld_q  <= 1'b0;
      end else if (en) begin
        addr_q <= addr_d;
        vld_q  <= vld_d;
      end
    end

    assign ent_addr[g]  = addr_q;
    assign ent_valid[g] = vld_q;
  end
endmodule

// File: rtl/rsf_match.sv
module rsf_match
  import rsf_pkg::*;
#(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned IDXW  = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lk_vld,
  input  logic [MAC_W-1:0]            lk_da,
  input  logic [DEPTH-1:0][MAC_W-1:0] ent_addr,
  input  logic [DEPTH-1:0]            ent_valid,
  output logic                        hit_vld,
  output logic                        hit,
  output logic [IDXW-1:0]             hit_idx
);
  logic [DEPTH-1:0] eq;
  logic [IDXW-1:0]  first_idx;
  logic             any_eq;
  logic             vld_d, hit_d;
  logic [IDXW-1:0]  idx_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = ent_valid[g] && (ent_addr[g] == lk_da);
  end

  always_comb begin
    first_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (eq[i]) first_idx = IDXW'(i);
    end
    any_eq = |eq;
  end

  always_comb begin
    vld_d = lk_vld;
    hit_d = lk_vld && any_eq;
    idx_d = hit_d ? first_idx : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_vld <= 1'b0;
      hit     <= 1'b0;
      hit_idx <= '0;
    end else begin
      hit_vld <= vld_d;
      hit     <= hit_d;
      hit_idx <= idx_d;
    end
  end
endmodule

// File: rtl/rx_station_filter.sv
module rx_station_filter
  import rsf_pkg::*;
#(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned IDXW  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [IDXW-1:0]  cfg_wr_idx,
  input  logic             cfg_wr_hi,
  input  logic [31:0]      cfg_wr_data,
  input  logic             alt_req,
  input  logic [15:0]      alt_ptr,
  input  logic [47:0]      alt_addr,
  input  logic             lookup_vld,
  input  logic [47:0]      lookup_da,
  output logic             hit_vld,
  output logic             hit,
  output logic [IDXW-1:0]  hit_idx
);
  logic                        alt_take;
  logic [DEPTH-1:0][MAC_W-1:0] tbl_addr;
  logic [DEPTH-1:0]            tbl_valid;

  rsf_alt_gate u_alt (
    .alt_req  (alt_req),
    .alt_ptr  (alt_ptr),
    .alt_addr (alt_addr),
    .alt_take (alt_take)
  );

  rsf_entry_bank #(.DEPTH(DEPTH)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_idx    (cfg_wr_idx),
    .wr_hi     (cfg_wr_hi),
    .wr_data   (cfg_wr_data),
    .alt_take  (alt_take),
    .alt_addr  (alt_addr),
    .ent_addr  (tbl_addr),
    .ent_valid (tbl_valid)
  );

  rsf_match #(.DEPTH(DEPTH)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_vld    (lookup_vld),
    .lk_da     (lookup_da),
    .ent_addr  (tbl_addr),
    .ent_valid (tbl_valid),
    .hit_vld   (hit_vld),
    .hit       (hit),
    .hit_idx   (hit_idx)
  );
endmodule

// File: rtl/rsf_checker.sv
module rsf_checker #(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned IDXW  = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_en,
  input logic [IDXW-1:0]  cfg_wr_idx,
  input logic             cfg_wr_hi,
  input logic             alt_req,
  input logic [15:0]      alt_ptr,
  input logic [47:0]      alt_addr,
  input logic             lookup_vld,
  input logic             hit_vld,
  input logic             hit,
  input logic [IDXW-1:0]  hit_idx,
  input logic [47:0]      ent0,
  input logic [DEPTH-1:0] ent_valid
);
  logic [DEPTH-1:0] valid_prev;
  logic             wr_ent0;

  assign wr_ent0 = cfg_wr_en && (cfg_wr_idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_prev <= '0;
    else        valid_prev <= ent_valid;
  end

  // R6
  hit_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_vld |=> hit_vld);

  // R6
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_vld |=> !hit_vld);

  // R6
  miss_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_idx == '0));

  // R4
  hit_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (hit_vld && valid_prev[hit_idx]));

  // R3
  low_invalidates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && !cfg_wr_hi && cfg_wr_idx != '0) |=> !ent_valid[$past(cfg_wr_idx)]);

  // R9
  bad_ptr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_req && (alt_ptr == 16'h0000 || alt_ptr == 16'hFFFF) && !wr_ent0)
      |=> ($stable(ent0) && $stable(ent_valid[0])));

  // R10
  group_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_req && alt_addr[0] && !wr_ent0)
      |=> ($stable(ent0) && $stable(ent_valid[0])));
endmodule

bind rx_station_filter rsf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr_en  (cfg_wr_en),
  .cfg_wr_idx (cfg_wr_idx),
  .cfg_wr_hi  (cfg_wr_hi),
  .alt_req    (alt_req),
  .alt_ptr    (alt_ptr),
  .alt_addr   (alt_addr),
  .lookup_vld (lookup_vld),
  .hit_vld    (hit_vld),
  .hit        (hit),
  .hit_idx    (hit_idx),
  .ent0       (tbl_addr[0]),
  .ent_valid  (tbl_valid)
);

// File: tb/rx_station_filter_bench.sv
module rx_station_filter_bench;
  localparam int DEPTH = 16;
  localparam int IDXW  = $clog2(DEPTH);

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_wr_en;
  logic [IDXW-1:0] cfg_wr_idx;
  logic            cfg_wr_hi;
  logic [31:0]     cfg_wr_data;
  logic            alt_req;
  logic [15:0]     alt_ptr;
  logic [47:0]     alt_addr;
  logic            lookup_vld;
  logic [47:0]     lookup_da;
  logic            hit_vld, hit;
  logic [IDXW-1:0] hit_idx;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_tag = "R1";

  // behavioural reference table
  logic [31:0] m_lo [DEPTH];
  logic [15:0] m_hi [DEPTH];
  bit          m_v  [DEPTH];
  bit          e_vld, e_hit;
  int          e_idx;

  always #5 clk = ~clk;

  rx_station_filter #(.DEPTH(DEPTH)) u_rx_station_filter (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_hi(cfg_wr_hi),
    .cfg_wr_data(cfg_wr_data),
    .alt_req(alt_req), .alt_ptr(alt_ptr), .alt_addr(alt_addr),
    .lookup_vld(lookup_vld), .lookup_da(lookup_da),
    .hit_vld(hit_vld), .hit(hit), .hit_idx(hit_idx)
  );

  // model: result from the table as it stood at the edge, then the writes
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        m_lo[i] = '0; m_hi[i] = '0; m_v[i] = 0;
      end
      e_vld = 0; e_hit = 0; e_idx = 0;
    end else begin
      e_vld = lookup_vld;
      e_hit = 0;
      e_idx = 0;
      if (lookup_vld) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (!e_hit && m_v[i] && {m_hi[i], m_lo[i]} == lookup_da) begin
            e_hit = 1;
            e_idx = i;
          end
        end
      end
      if (cfg_wr_en) begin
        if (!cfg_wr_hi) begin
          m_lo[cfg_wr_idx] = cfg_wr_data;
          m_v[cfg_wr_idx]  = 0;
        end else begin
          m_hi[cfg_wr_idx] = cfg_wr_data[15:0];
          m_v[cfg_wr_idx]  = ({cfg_wr_data[15:0], m_lo[cfg_wr_idx]} != 48'd0);
        end
      end
      if (alt_req && alt_ptr != 16'h0000 && alt_ptr != 16'hFFFF && !alt_addr[0]) begin
        m_lo[0] = alt_addr[31:0];
        m_hi[0] = alt_addr[47:32];
        m_v[0]  = (alt_addr != 48'd0);
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      n_tests++;
      if (hit_vld !== e_vld || hit !== e_hit || int'(hit_idx) != e_idx) begin
        n_fail++;
        $display("FAIL %s model: act vld=%0b hit=%0b idx=%0d exp vld=%0b hit=%0b idx=%0d",
                 cur_tag, hit_vld, hit, hit_idx, e_vld, e_hit, e_idx);
      end
    end
  end

  task automatic wr(input int idx, input bit hi_w, input logic [31:0] d);
    cfg_wr_en = 1; cfg_wr_idx = IDXW'(idx); cfg_wr_hi = hi_w; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  task automatic put(input int idx, input logic [47:0] a);
    wr(idx, 0, a[31:0]);
    wr(idx, 1, {16'h0, a[47:32]});
  endtask

  task automatic alt(input logic [15:0] p, input logic [47:0] a);
    alt_req = 1; alt_ptr = p; alt_addr = a;
    @(negedge clk);
    alt_req = 0;
  endtask

  task automatic look(input string tag, input logic [47:0] da, input bit eh, input int ei);
    cur_tag = tag;
    lookup_vld = 1; lookup_da = da;
    @(negedge clk);
    lookup_vld = 0;
    n_tests++;
    if (hit_vld !== 1'b1 || hit !== eh || int'(hit_idx) != ei) begin
      n_fail++;
      $display("FAIL %s da=%h: act vld=%0b hit=%0b idx=%0d exp vld=1 hit=%0b idx=%0d",
               tag, da, hit_vld, hit, hit_idx, eh, ei);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act running exp finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_wr_en = 0; cfg_wr_idx = '0; cfg_wr_hi = 0; cfg_wr_data = '0;
    alt_req = 0; alt_ptr = '0; alt_addr = '0; lookup_vld = 0; lookup_da = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    n_tests++;
    if (hit_vld !== 0 || hit !== 0 || hit_idx !== '0) begin
      n_fail++;
      $display("FAIL R1 reset outputs: act %0b%0b%0d exp 000", hit_vld, hit, hit_idx);
    end
    // R1: empty table
    look("R1", 48'h0123_4567_89AB, 0, 0);
    look("R1", 48'h0, 0, 0);
    // R2: bytes 02 11 22 33 44 55 in entry 3
    wr(3, 0, 32'h3322_1102);
    wr(3, 1, 32'h0000_5544);
    look("R2", 48'h5544_3322_1102, 1, 3);
    look("R2", 48'h0211_2233_4455, 0, 0);
    // R3: low word only, then high word, then rewrite low
    wr(5, 0, 32'hCAFE_0A0C);
    look("R3", 48'h0000_CAFE_0A0C, 0, 0);
    wr(5, 1, 32'h0000_0000);
    look("R3", 48'h0000_CAFE_0A0C, 1, 5);
    wr(3, 0, 32'h3322_1102);
    look("R3", 48'h5544_3322_1102, 0, 0);
    wr(3, 1, 32'h0000_5544);
    look("R3", 48'h5544_3322_1102, 1, 3);
    // R4: all-zero entry never valid
    put(6, 48'h0);
    look("R4", 48'h0, 0, 0);
    // R5: upper high-word bits ignored
    wr(7, 0, 32'h0000_0077);
    wr(7, 1, 32'hABCD_0066);
    look("R5", 48'h0066_0000_0077, 1, 7);
    look("R5", 48'hABCD_0000_0077, 0, 0);
    // R7: duplicates resolve to lowest index
    put(12, 48'h1E1E_2D2D_3C3C);
    put(9,  48'h1E1E_2D2D_3C3C);
    look("R7", 48'h1E1E_2D2D_3C3C, 1, 9);
    put(2,  48'h1E1E_2D2D_3C3C);
    look("R7", 48'h1E1E_2D2D_3C3C, 1, 2);
    wr(2, 0, 32'h0);
    look("R7", 48'h1E1E_2D2D_3C3C, 1, 9);
    // R6: back-to-back lookups
    cur_tag = "R6";
    lookup_vld = 1; lookup_da = 48'h0066_0000_0077;
    @(negedge clk);
    n_tests++;
    if (!(hit_vld && hit && hit_idx == 4'd7)) begin
      n_fail++;
      $display("FAIL R6 first: act %0b%0b%0d exp 1 1 7", hit_vld, hit, hit_idx);
    end
    lookup_da = 48'h0000_CAFE_0A0C;
    @(negedge clk);
    lookup_vld = 0;
    n_tests++;
    if (!(hit_vld && hit && hit_idx == 4'd5)) begin
      n_fail++;
      $display("FAIL R6 second: act %0b%0b%0d exp 1 1 5", hit_vld, hit, hit_idx);
    end
    repeat (3) @(negedge clk);
    // R8: primary, then accepted alternate
    put(0, 48'h00AA_BBCC_DD00);
    look("R8", 48'h00AA_BBCC_DD00, 1, 0);
    alt(16'h0040, 48'hAABB_CCDD_EE10);
    look("R8", 48'hAABB_CCDD_EE10, 1, 0);
    look("R8", 48'h00AA_BBCC_DD00, 0, 0);
    // R9: empty pointers rejected
    alt(16'hFFFF, 48'h1111_2222_3330);
    look("R9", 48'h1111_2222_3330, 0, 0);
    alt(16'h0000, 48'h1111_2222_3330);
    look("R9", 48'h1111_2222_3330, 0, 0);
    look("R9", 48'hAABB_CCDD_EE10, 1, 0);
    // R10: group alternate rejected
    alt(16'h0040, 48'h4444_5555_6611);
    look("R10", 48'h4444_5555_6611, 0, 0);
    look("R10", 48'hAABB_CCDD_EE10, 1, 0);
    // R11: alternate wins over a same-cycle write to entry 0
    cur_tag = "R11";
    cfg_wr_en = 1; cfg_wr_idx = '0; cfg_wr_hi = 1; cfg_wr_data = 32'h0000_9999;
    alt_req = 1; alt_ptr = 16'h0123; alt_addr = 48'h7777_8888_9902;
    @(negedge clk);
    cfg_wr_en = 0; alt_req = 0;
    look("R11", 48'h7777_8888_9902, 1, 0);
    look("R11", 48'h9999_CCDD_EE10, 0, 0);
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule